// File: doc/BRIEF.md
# Register-Bus UART with Programmable Line Format

This block is an asynchronous serial transmitter and receiver that a processor drives through a small 32-bit register bus. Software sets a 12-bit bit-rate divisor split across two registers, picks the character format in a line-control register and then switches the port on through an enable register. After that, a write to the data register queues a character for sending and a read pops a received character. Each received character carries its own framing, parity and overrun status. That status can be read from the status register directly after the data read.

The character format covers 5 to 8 data bits, no parity or odd or even parity, and one or two stop bits. A line-control bit holds the transmit line low for a break. Another line-control bit selects between 16-entry queues in both directions and single-entry holding registers. Two level outputs tell the processor that the transmit side can take a character and that the receive side holds one.

Register offsets (word index on `bus_addr`): 0 data, 1 receive status, 2 divisor low, 3 divisor high, 4 line control, 5 enable, 6 flags.

Top module: `mmio_uart`

## Requirements
- R1: After reset `txd` is high and `irq_rx` is low. `irq_tx` is high. The flag register reads 0x10, which means only the receive-empty flag is set. The enable register reads 0.
- R2: Divisor-low register bits 7:0 hold divisor bits 7:0, and divisor-high bits 3:0 hold divisor bits 11:8. Both read back, with the unused high bits reading 0. One bit on `txd` lasts 16 × (divisor + 1) clock cycles.
- R3: Line-control bits 6:0 read back. Their fields are:
  - bit 0: break
  - bit 1: parity enable
  - bit 2: even parity (odd when clear)
  - bit 3: two stop bits
  - bit 4: queue mode
  - bits 6:5: word length, where 00, 01, 10 and 11 give 5, 6, 7 and 8 bits

  A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then the high stop bit or bits. A frame sent and received in the same format returns its data with status 0.
- R4: A received character shorter than 8 bits reads with its unused upper data bits at 0.
- R5: A data read latches the status of the popped character into the status register:
  - bit 0: framing error (stop bit sampled low)
  - bit 1: parity mismatch
  - bit 2: overrun

  The status register changes on no other event.
- R6: A low pulse on `rxd` that ends before the middle of a start bit does not produce a character.
- R7: With queue mode on, each direction holds 16 characters. Flag bit 5 goes high when the transmit side is full, and a data write while it is full is discarded.
- R8: With queue mode off, each direction holds one character besides the one being shifted. A second character that arrives before the first is read is dropped.
- R9: A character that arrives while the receive side is full is dropped, and the next character stored carries the overrun bit.
- R10: While the break bit is set, `txd` stays low. Clearing the bit returns the line to idle high.
- R11: Writing 0 to the enable register stops the port and empties both directions, and data writes are then discarded. Writing 1 restarts the port.
- R12: Flag bit 3 is high while a character is queued or being shifted out, and low once the line is idle.
- R13: `irq_rx` is high while a received character is waiting. `irq_tx` is high while the transmit side is not full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the bit-rate reference |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; on the data offset it pops a character |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq_tx | output | 1 | Transmit side can accept a character |
| irq_rx | output | 1 | Receive side holds a character |

## Verification
A broken receive sampler or a wrong bit counter shows up within one character time. The data read back differs from the data sent, or a framing or parity bit appears in the status register. A queue occupancy that is off by one shows at the ports when the full flag rises one write early or late. It also shows when the overrun bit lands on the wrong character some hundreds of cycles later. A transmitter left in a non-idle state after disable or break is seen on `txd` within two cycles.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        REG_DATA  = 3'd0,
        REG_RXST  = 3'd1,
        REG_DIVLO = 3'd2,
        REG_DIVHI = 3'd3,
        REG_LINE  = 3'd4,
        REG_ENA   = 3'd5,
        REG_FLAG  = 3'd6
    } reg_sel_e;

    // bit positions follow the software-visible line-control layout
    typedef struct packed {
        logic [1:0] wlen;
        logic       fifo_on;
        logic       stop2;
        logic       even;
        logic       par_on;
        logic       brk;
    } line_cfg_t;

    typedef struct packed {
        logic ovr;
        logic par_err;
        logic frm_err;
    } rx_stat_t;

    typedef struct packed {
        rx_stat_t          st;
        logic [CHAR_W-1:0] data;
    } rx_word_t;

    // index of the last data bit: word length minus one
    function automatic logic [3:0] last_bit_idx(input logic [1:0] wlen);
        return {2'b01, wlen};
    endfunction

    function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] wlen);
        return 8'hFF >> (2'd3 - wlen);
    endfunction

    function automatic logic frame_parity(input logic [CHAR_W-1:0] data, input line_cfg_t cfg);
        logic x;
        x = ^(data & char_mask(cfg.wlen));
        return cfg.even ? x : ~x;
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             deep,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cap;
    logic             do_push, do_pop;

    assign cap     = deep ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full    = count >= cap;
    assign empty   = count == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              have_data,
    input  logic [CHAR_W-1:0] data,
    output logic              pop,
    output logic              line,
    output logic              active
);
    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_state_e;

    tx_state_e         state;
    logic [CHAR_W-1:0] shreg;
    logic [3:0]        tcnt;
    logic [2:0]        bidx;
    logic              par_q, extra_stop;

    assign pop    = (state == T_IDLE) && have_data;
    assign active = state != T_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= T_IDLE;
            shreg      <= '0;
            tcnt       <= '0;
            bidx       <= '0;
            par_q      <= 1'b0;
            extra_stop <= 1'b0;
        end else if (state == T_IDLE) begin
            if (have_data) begin
                shreg      <= data;
                par_q      <= frame_parity(data, cfg);
                extra_stop <= cfg.stop2;
                tcnt       <= '0;
                bidx       <= '0;
                state      <= T_START;
            end
        end else if (tick) begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'd15) begin
                case (state)
                    T_START: state <= T_DATA;
                    T_DATA: begin
                        shreg <= shreg >> 1;
                        bidx  <= bidx + 3'd1;
                        if ({1'b0, bidx} == last_bit_idx(cfg.wlen))
                            state <= cfg.par_on ? T_PAR : T_STOP;
                    end
                    T_PAR: state <= T_STOP;
                    default: begin
                        if (extra_stop) extra_stop <= 1'b0;
                        else            state      <= T_IDLE;
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            T_START: line = 1'b0;
            T_DATA:  line = shreg[0];
            T_PAR:   line = par_q;
            default: line = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              rxd,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output logic              frm_err,
    output logic              par_err
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_state_e;

    rx_state_e  state;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic       sample;

    // a data, parity or stop bit is taken 16 ticks after the previous one
    assign sample = tick && (tcnt == 4'd15);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= R_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            data    <= '0;
            done    <= 1'b0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                R_IDLE: if (tick && !rxd) begin
                    tcnt  <= '0;
                    state <= R_START;
                end
                R_START: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (tcnt == 4'd6) begin
                        if (!rxd) begin
                            tcnt    <= '0;
                            bidx    <= '0;
                            data    <= '0;
                            par_err <= 1'b0;
                            state   <= R_DATA;
                        end else begin
                            state <= R_IDLE;
                        end
                    end
                end
                R_DATA: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (sample) begin
                        data[bidx] <= rxd;
                        bidx       <= bidx + 3'd1;
                        if ({1'b0, bidx} == last_bit_idx(cfg.wlen))
                            state <= cfg.par_on ? R_PAR : R_STOP;
                    end
                end
                R_PAR: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (sample) begin
                        par_err <= rxd != frame_parity(data, cfg);
                        state   <= R_STOP;
                    end
                end
                default: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (sample) begin
                        frm_err <= !rxd;
                        done    <= 1'b1;
                        state   <= R_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart import uart_pkg::*; #(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 12,
    parameter int BUS_W      = 32,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq_tx,
    output logic              irq_rx
);
    localparam int LO_W   = 8;
    localparam int HI_W   = DIV_W - LO_W;
    localparam int LINE_W = $bits(line_cfg_t);
    localparam int WORD_W = $bits(rx_word_t);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    reg_sel_e   sel;
    logic [DIV_W-1:0] div_q, baud_cnt;
    line_cfg_t  line_q;
    logic       en_q, eng_rst, tick;
    rx_stat_t   rxst_q;
    logic       ovr_pend, txd_q, rxd_s1, rxd_s2;

    logic              tx_push, tx_pop, tx_full, tx_empty, tx_line, tx_active, busy;
    logic [CHAR_W-1:0] tx_dout;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              rx_done, rx_frm, rx_par, rx_push, rx_pop, rx_full, rx_empty;
    logic [CHAR_W-1:0] rx_data;
    rx_word_t          rx_din, rx_dout;
    logic              unused_bits;

    assign sel         = reg_sel_e'(bus_addr[2:0]);
    assign eng_rst     = rst || !en_q;
    assign tick        = en_q && (baud_cnt >= div_q);
    assign tx_push     = bus_wr && (sel == REG_DATA) && en_q;
    assign rx_pop      = bus_rd && (sel == REG_DATA);
    assign rx_push     = rx_done && !rx_full;
    assign rx_din      = '{st: '{ovr: ovr_pend, par_err: rx_par, frm_err: rx_frm}, data: rx_data};
    assign busy        = tx_active || !tx_empty;
    assign txd         = txd_q;
    assign irq_tx      = !tx_full;
    assign irq_rx      = !rx_empty;
    assign unused_bits = ^{bus_wdata[BUS_W-1:LO_W], rx_count};

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            line_q <= '0;
            en_q   <= 1'b0;
        end else if (bus_wr) begin
            case (sel)
                REG_DIVLO: div_q[LO_W-1:0]     <= bus_wdata[LO_W-1:0];
                REG_DIVHI: div_q[DIV_W-1:LO_W] <= bus_wdata[HI_W-1:0];
                REG_LINE:  line_q              <= line_cfg_t'(bus_wdata[LINE_W-1:0]);
                REG_ENA:   en_q                <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // 16x bit-rate tick
    always_ff @(posedge clk) begin
        if (eng_rst)   baud_cnt <= '0;
        else if (tick) baud_cnt <= '0;
        else           baud_cnt <= baud_cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_s1 <= 1'b1;
            rxd_s2 <= 1'b1;
            txd_q  <= 1'b1;
            rxst_q <= '0;
        end else begin
            rxd_s1 <= rxd;
            rxd_s2 <= rxd_s1;
            txd_q  <= line_q.brk ? 1'b0 : tx_line;
            if (rx_pop && !rx_empty) rxst_q <= rx_dout.st;
        end
    end

    always_ff @(posedge clk) begin
        if (eng_rst)      ovr_pend <= 1'b0;
        else if (rx_done) ovr_pend <= rx_full;
    end

    uart_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(!en_q), .deep(line_q.fifo_on),
        .push(tx_push), .din(bus_wdata[CHAR_W-1:0]), .pop(tx_pop),
        .dout(tx_dout), .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    uart_tx u_tx (
        .clk(clk), .rst(eng_rst), .tick(tick), .cfg(line_q),
        .have_data(!tx_empty), .data(tx_dout), .pop(tx_pop),
        .line(tx_line), .active(tx_active)
    );

    uart_rx u_rx (
        .clk(clk), .rst(eng_rst), .tick(tick), .cfg(line_q), .rxd(rxd_s2),
        .done(rx_done), .data(rx_data), .frm_err(rx_frm), .par_err(rx_par)
    );

    uart_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(!en_q), .deep(line_q.fifo_on),
        .push(rx_push), .din(rx_din), .pop(rx_pop),
        .dout(rx_dout), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_DATA:  bus_rdata[CHAR_W-1:0] = rx_empty ? '0 : rx_dout.data;
            REG_RXST:  bus_rdata[2:0]        = rxst_q;
            REG_DIVLO: bus_rdata[LO_W-1:0]   = div_q[LO_W-1:0];
            REG_DIVHI: bus_rdata[HI_W-1:0]   = div_q[DIV_W-1:LO_W];
            REG_LINE:  bus_rdata[LINE_W-1:0] = line_q;
            REG_ENA:   bus_rdata[0]          = en_q;
            REG_FLAG:  bus_rdata[5:3]        = {tx_full, rx_empty, busy};
            default: ;
        endcase
    end
endmodule

// File: rtl/uart_checks.sv
module uart_checks #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             txd,
    input logic             brk,
    input logic             en,
    input logic             busy,
    input logic             tx_full,
    input logic             tx_pop,
    input logic [CNT_W-1:0] tx_count,
    input logic             bus_rd,
    input logic [2:0]       sel_addr,
    input logic [2:0]       rxst
);
    assert_break_low_R10: assert property (@(posedge clk) disable iff (rst)
        brk |=> !txd);

    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(en, 2) && !$past(brk)) |-> txd);

    assert_idle_high_R12: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy) && !$past(brk)) |-> txd);

    assert_full_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en && tx_full && !tx_pop) |=> (tx_count == $past(tx_count)));

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CNT_W'(DEPTH));

    assert_status_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && sel_addr == 3'd0) |=> $stable(rxst));
endmodule

bind mmio_uart uart_checks #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst(rst), .txd(txd), .brk(line_q.brk), .en(en_q), .busy(busy),
    .tx_full(tx_full), .tx_pop(tx_pop), .tx_count(tx_count),
    .bus_rd(bus_rd), .sel_addr(bus_addr[2:0]), .rxst(rxst_q)
);

// File: tb/tb_mmio_uart.sv
`timescale 1ns/1ps
module tb_mmio_uart;
    localparam logic [2:0] A_DATA = 3'd0, A_RXST = 3'd1, A_DLO = 3'd2, A_DHI = 3'd3,
                           A_LINE = 3'd4, A_ENA = 3'd5, A_FLAG = 3'd6;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        txd, rxd, irq_tx, irq_rx;
    logic        loop_on = 1'b1, bench_rxd = 1'b1;
    int          n_checks = 0, n_bad = 0;
    bit          finished = 1'b0;

    assign rxd = loop_on ? txd : bench_rxd;

    always #2 clk = ~clk;

    mmio_uart dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [11:0] div, input logic [7:0] line);
        wr(A_ENA, 0);
        wr(A_DLO, {24'h0, div[7:0]});
        wr(A_DHI, {28'h0, div[11:8]});
        wr(A_LINE, {24'h0, line});
        wr(A_ENA, 1);
    endtask

    task automatic wait_rx(input int lim);
        for (int i = 0; i < lim && !irq_rx; i++) @(negedge clk);
    endtask

    // bench-driven frame, 16 cycles per bit (divisor 0)
    task automatic send_raw(input logic [7:0] d, input int nbits, input bit par_on,
                            input bit par_val, input bit stop_val);
        @(negedge clk);
        bench_rxd = 1'b0; idle(16);
        for (int i = 0; i < nbits; i++) begin bench_rxd = d[i]; idle(16); end
        if (par_on) begin bench_rxd = par_val; idle(16); end
        bench_rxd = stop_val;
        idle(stop_val ? 16 : 12);
        bench_rxd = 1'b1;
        idle(20);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 txd", 32'(txd), 1);
        check("R1 irq_rx", 32'(irq_rx), 0);
        check("R1 irq_tx", 32'(irq_tx), 1);
        rd(A_FLAG, v); check("R1 flags", v, 32'h10);
        rd(A_ENA, v);  check("R1 enable", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_DLO, 32'hFFFF_FFAB); wr(A_DHI, 32'h0000_00F5);
        rd(A_DLO, v); check("R2 div low", v, 32'hAB);
        rd(A_DHI, v); check("R2 div high", v, 32'h5);
        wr(A_LINE, 32'hFF); rd(A_LINE, v); check("R3 line readback", v, 32'h7F);
        wr(A_LINE, 32'h26); rd(A_LINE, v); check("R3 line readback", v, 32'h26);
    endtask

    task automatic t_loop(input logic [7:0] line, input logic [7:0] d, input logic [7:0] exp);
        logic [31:0] v;
        loop_on = 1'b1;
        cfg(0, line);
        wr(A_DATA, {24'h0, d});
        rd(A_FLAG, v); check("R12 busy while sending", v & 32'h8, 32'h8);
        wait_rx(600);
        check("R13 irq_rx on arrival", 32'(irq_rx), 1);
        rd(A_DATA, v); check("R3 R4 loop data", v, {24'h0, exp});
        rd(A_RXST, v); check("R5 clean status", v, 0);
        check("R13 irq_rx after read", 32'(irq_rx), 0);
        idle(40);
        rd(A_FLAG, v); check("R12 idle after frame", v, 32'h10);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        loop_on = 1'b0;
        cfg(0, 8'h66);
        send_raw(8'h3C, 8, 1'b1, 1'b1, 1'b1);   // even parity of 0x3C is 0
        wait_rx(200);
        rd(A_DATA, v); check("R5 parity data", v, 32'h3C);
        rd(A_RXST, v); check("R5 parity error bit1", v, 32'h2);
        cfg(0, 8'h60);
        send_raw(8'h81, 8, 1'b0, 1'b0, 1'b0);
        wait_rx(200);
        rd(A_DATA, v); check("R5 framing data", v, 32'h81);
        rd(A_RXST, v); check("R5 framing error bit0", v, 32'h1);
        idle(60);
        rd(A_FLAG, v); check("R5 no extra char", v & 32'h10, 32'h10);
        rd(A_RXST, v); check("R5 status holds", v, 32'h1);
    endtask

    task automatic t_glitch();
        logic [31:0] v;
        loop_on = 1'b0;
        cfg(0, 8'h60);
        @(negedge clk); bench_rxd = 1'b0; idle(3); bench_rxd = 1'b1;
        idle(300);
        rd(A_FLAG, v); check("R6 short pulse rejected", v & 32'h10, 32'h10);
    endtask

    task automatic t_bittime();
        logic [31:0] v;
        int n = 0;
        loop_on = 1'b1;
        cfg(3, 8'h60);
        wr(A_DATA, 32'h01);
        for (int i = 0; i < 200 && txd; i++) @(negedge clk);
        for (int i = 0; i < 200 && !txd; i++) @(negedge clk);
        while (txd && n < 500) begin n++; @(negedge clk); end
        check("R2 bit time div=3", n, 64);
        wait_rx(2000);
        rd(A_DATA, v); check("R2 data at div=3", v, 32'h01);
    endtask

    task automatic t_fifo();
        logic [31:0] v;
        loop_on = 1'b1;
        cfg(0, 8'h70);
        for (int i = 0; i < 17; i++) wr(A_DATA, 32'(8'h11 + i));
        rd(A_FLAG, v); check("R7 tx full flag", v & 32'h20, 32'h20);
        check("R13 irq_tx low when full", 32'(irq_tx), 0);
        idle(17 * 170 + 200);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v); check("R7 queued data", v, 32'(8'h11 + i));
            rd(A_RXST, v); check("R7 queued status", v, 0);
        end
        rd(A_FLAG, v); check("R9 dropped char", v & 32'h10, 32'h10);
        wr(A_DATA, 32'h5A);
        wait_rx(600);
        rd(A_DATA, v); check("R9 next data", v, 32'h5A);
        rd(A_RXST, v); check("R9 overrun bit2", v, 32'h4);
    endtask

    task automatic t_holding();
        logic [31:0] v;
        loop_on = 1'b1;
        cfg(0, 8'h60);
        wr(A_DATA, 32'h31); wr(A_DATA, 32'h32); wr(A_DATA, 32'h33);
        rd(A_FLAG, v); check("R8 holding full", v & 32'h20, 32'h20);
        idle(600);
        rd(A_DATA, v); check("R8 first held char", v, 32'h31);
        rd(A_RXST, v); check("R8 first status", v, 0);
        rd(A_FLAG, v); check("R8 second dropped", v & 32'h10, 32'h10);
        wr(A_DATA, 32'h77);
        wait_rx(600);
        rd(A_DATA, v); check("R8 R9 later data", v, 32'h77);
        rd(A_RXST, v); check("R8 R9 overrun flagged", v, 32'h4);
    endtask

    task automatic t_break();
        cfg(0, 8'h61);
        idle(5);  check("R10 break low", 32'(txd), 0);
        idle(100); check("R10 break still low", 32'(txd), 0);
        wr(A_LINE, 32'h60);
        idle(3);  check("R10 idle after break", 32'(txd), 1);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        loop_on = 1'b1;
        cfg(0, 8'h60);
        wr(A_ENA, 0);
        wr(A_DATA, 32'h44);
        rd(A_FLAG, v); check("R11 write ignored when off", v, 32'h10);
        rd(A_ENA, v);  check("R11 enable reads 0", v, 0);
        idle(200);
        check("R11 line idle when off", 32'(txd), 1);
        wr(A_ENA, 1);
        idle(300);
        rd(A_FLAG, v); check("R11 nothing sent after re-enable", v, 32'h10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_loop(8'h60, 8'hA5, 8'hA5);
        t_loop(8'h4E, 8'hC3, 8'h43);
        t_loop(8'h02, 8'hFF, 8'h1F);
        t_loop(8'h26, 8'h2A, 8'h2A);
        t_errors();
        t_glitch();
        t_bittime();
        t_fifo();
        t_holding();
        t_break();
        t_disable();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=complete");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule